// File: doc/BRIEF.md
# Flash Program, Erase and Read Sequencer

This block runs one complete flash operation on a target device whose flash controller is reached only through indirect registers. A host picks an operation (byte program, page erase or byte read), an address and, for a program, a data byte, and pulses `start`. The sequencer then issues a fixed chain of register accesses to an access layer: it loads the flash timing scale, the flash address and a mode code into the control register. It touches the data register to launch the operation, switches the control register to a polling mode, and reads the data register one bit at a time until the busy flag drops. A last, wider status read yields the fail flag and, for a read, the byte.

The access layer is reached through a request/acknowledge port. `accReq` stays high with the access fields stable until the layer pulses `accAck` for one cycle. `accRData` carries the returned bits, right-aligned. If `accReq` is still high in the cycle after an acknowledge, that cycle begins the next access. An `accErr` pulse raised with the acknowledge reports a failed access. It ends the sequence at once.

Top module: `flashprog_seq`

## Requirements
- R1: After reset `accReq`, `done` and `fail` are 0 and `rdByte` is 0x00.
- R2: Operation codes on `op` are 0 = program byte, 1 = erase page and 2 = read byte. A `start` pulse is taken only while the block is idle. A `start` pulse with `op` = 3, or one given while a sequence is running, has no effect.
- R3: Register selects on `accRegSel` are 0 = timing scale, 1 = address, 2 = control and 3 = data. The first access writes the timing scale with length 8, using value 0x80 for a read and 0x81 otherwise. The second access writes the address with length ADDR_W.
- R4: The third access writes the control register with length 8. The mode code is 0x10 for program, 0x20 for erase and 0x02 for read, with `ctlBit7` placed in bit 7. The fifth access writes the control register with 0x00, again with `ctlBit7` in bit 7.
- R5: The fourth access targets the data register. For a program it is an 8-bit write of `wrData`. For an erase it is an 8-bit write of 0xA5. For a read it is a 10-bit read.
- R6: After the poll-mode write, the block issues 1-bit reads of the data register. It repeats them while returned bit 0 (busy) is 1, and goes on once bit 0 is 0.
- R7: The final access is a data-register read of 2 bits (program and erase) or 10 bits (read). `fail` takes returned bit 1. `rdByte` takes returned bits 9:2 for a read and is 0x00 for a program or erase.
- R8: While `accReq` is high and no acknowledge has arrived, `accRegSel`, `accWrite`, `accLen` and `accWData` are stable. A read access drives `accWData` to zero.
- R9: An acknowledge carrying `accErr` stops the chain. No further access is issued, and the block ends with `fail` = 1 and `rdByte` = 0x00.
- R10: `done` is a single-cycle pulse in the cycle after the last acknowledge, and `accReq` is low during it. `fail` and `rdByte` hold their values until the next sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one operation |
| op | input | 2 | Operation select |
| addr | input | ADDR_W | Flash byte or page address |
| wrData | input | 8 | Byte to program |
| ctlBit7 | input | 1 | Value ORed into bit 7 of every control write |
| accReq | output | 1 | Access request to the register access layer |
| accWrite | output | 1 | 1 = register write, 0 = register read |
| accRegSel | output | 2 | Target register select |
| accLen | output | LEN_W | Access length in bits |
| accWData | output | ADDR_W | Write value, right-aligned |
| accAck | input | 1 | One-cycle completion of the current access |
| accErr | input | 1 | Access failure, valid with accAck |
| accRData | input | 10 | Returned bits, right-aligned |
| rdByte | output | 8 | Byte from the last read |
| fail | output | 1 | Operation failed |
| done | output | 1 | Sequence finished pulse |

## Verification
The assertions check the properties that hold on every cycle. These are the stability of the access fields while a request waits, the shape of every poll access, a poll that stays in place while busy is returned, and the abort on an access error. They also cover the single-cycle `done` with no request beside it, and the ignored reserved operation code. The bench alone can show that the whole access chain comes out in the right order with the right values for each operation, control bit and busy count. It also shows that the final status decodes into `fail` and `rdByte`, that a start pulse in mid-sequence changes nothing, and that an error at any point cuts the chain short.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SCALE, PH_ADDR, PH_MODE, PH_KICK,
    PH_PMODE, PH_POLL, PH_STAT, PH_DONE
  } phase_t;

  localparam logic [1:0] OP_PROG  = 2'd0;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  localparam logic [1:0] REG_SCALE = 2'd0;
  localparam logic [1:0] REG_ADDR  = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_DATA  = 2'd3;

  localparam logic [6:0] MODE_PROG  = 7'h10;
  localparam logic [6:0] MODE_ERASE = 7'h20;
  localparam logic [6:0] MODE_READ  = 7'h02;
  localparam logic [6:0] MODE_POLL  = 7'h00;

  localparam logic [7:0] SCALE_WR  = 8'h81;
  localparam logic [7:0] SCALE_RD  = 8'h80;
  localparam logic [7:0] ERASE_KEY = 8'hA5;

  localparam int STAT_W = 10;

  typedef struct packed {
    logic   latch;
    phase_t phase;
    logic   capStat;
    logic   capErr;
  } seqStrobe_t;

endpackage

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
  import flashprog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       accAck,
  input  logic       accErr,
  input  logic       busyBit,
  output seqStrobe_t str,
  output logic       accReq,
  output logic       done
);

  phase_t phase, phaseNext;
  logic   ackOk;

  assign accReq = phase inside {PH_SCALE, PH_ADDR, PH_MODE, PH_KICK, PH_PMODE, PH_POLL, PH_STAT};
  assign done   = (phase == PH_DONE);
  assign ackOk  = accAck && !accErr;

  always_comb begin
    phaseNext   = phase;
    str.latch   = 1'b0;
    str.capStat = 1'b0;
    str.capErr  = 1'b0;
    str.phase   = phase;
    case (phase)
      PH_IDLE: if (start && op != 2'd3) begin
        phaseNext = PH_SCALE;
        str.latch = 1'b1;
      end
      PH_DONE: phaseNext = PH_IDLE;
      default: begin
        if (accAck && accErr) begin
          phaseNext  = PH_DONE;
          str.capErr = 1'b1;
        end else if (ackOk) begin
          case (phase)
            PH_SCALE: phaseNext = PH_ADDR;
            PH_ADDR:  phaseNext = PH_MODE;
            PH_MODE:  phaseNext = PH_KICK;
            PH_KICK:  phaseNext = PH_PMODE;
            PH_PMODE: phaseNext = PH_POLL;
            PH_POLL:  phaseNext = busyBit ? PH_POLL : PH_STAT;
            PH_STAT: begin
              phaseNext   = PH_DONE;
              str.capStat = 1'b1;
            end
            default:  phaseNext = PH_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    accReq && accAck && accErr |=> done && !accReq);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !accReq);

  // R2
  bad_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accReq && !done && start && op == 2'd3 |=> !accReq);

  // R6
  poll_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_POLL && accAck && !accErr && busyBit |=> phase == PH_POLL);

endmodule

// File: rtl/flashprog_dp.sv
module flashprog_dp
  import flashprog_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int LEN_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        str,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              ctlBit7,
  input  logic              accAck,
  input  logic [STAT_W-1:0] accRData,
  output logic [1:0]        accRegSel,
  output logic              accWrite,
  output logic [LEN_W-1:0]  accLen,
  output logic [ADDR_W-1:0] accWData,
  output logic [7:0]        rdByte,
  output logic              fail
);

  localparam int PAD_W = ADDR_W - 8;

  logic [1:0]        opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic              b7Q;
  logic [6:0]        modeCode;
  logic              isRead;

  assign isRead = (opQ == OP_READ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_PROG;
      addrQ <= '0;
      dataQ <= '0;
      b7Q   <= 1'b0;
    end else if (str.latch) begin
      opQ   <= op;
      addrQ <= addr;
      dataQ <= wrData;
      b7Q   <= ctlBit7;
    end
  end

  always_comb begin
    case (opQ)
      OP_ERASE: modeCode = MODE_ERASE;
      OP_READ:  modeCode = MODE_READ;
      default:  modeCode = MODE_PROG;
    endcase
  end

  always_comb begin
    accRegSel = REG_DATA;
    accWrite  = 1'b0;
    accLen    = LEN_W'(1);
    accWData  = '0;
    case (str.phase)
      PH_SCALE: begin
        accRegSel = REG_SCALE;
        accWrite  = 1'b1;
        accLen    = LEN_W'(8);
        accWData  = {{PAD_W{1'b0}}, (isRead ? SCALE_RD : SCALE_WR)};
      end
      PH_ADDR: begin
        accRegSel = REG_ADDR;
        accWrite  = 1'b1;
        accLen    = LEN_W'(ADDR_W);
        accWData  = addrQ;
      end
      PH_MODE: begin
        accRegSel = REG_CTRL;
        accWrite  = 1'b1;
        accLen    = LEN_W'(8);
        accWData  = {{PAD_W{1'b0}}, b7Q, modeCode};
      end
      PH_KICK: begin
        accWrite = !isRead;
        accLen   = isRead ? LEN_W'(STAT_W) : LEN_W'(8);
        if (!isRead)
          accWData = {{PAD_W{1'b0}}, (opQ == OP_ERASE ? ERASE_KEY : dataQ)};
      end
      PH_PMODE: begin
        accRegSel = REG_CTRL;
        accWrite  = 1'b1;
        accLen    = LEN_W'(8);
        accWData  = {{PAD_W{1'b0}}, b7Q, MODE_POLL};
      end
      PH_STAT: accLen = isRead ? LEN_W'(STAT_W) : LEN_W'(2);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail   <= 1'b0;
      rdByte <= '0;
    end else if (str.capErr) begin
      fail   <= 1'b1;
      rdByte <= '0;
    end else if (str.capStat) begin
      fail   <= accRData[1];
      rdByte <= isRead ? accRData[STAT_W-1:2] : 8'h00;
    end
  end

  // R8
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.phase inside {PH_SCALE, PH_ADDR, PH_MODE, PH_KICK, PH_PMODE, PH_POLL, PH_STAT}) && !accAck
    |=> $stable(accRegSel) && $stable(accWrite) && $stable(accLen) && $stable(accWData));

  // R6
  poll_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.phase == PH_POLL |-> accLen == LEN_W'(1) && !accWrite && accRegSel == REG_DATA && accWData == '0);

  // R9
  err_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.capErr |=> fail && rdByte == 8'h00);

endmodule

// File: rtl/flashprog_seq.sv
module flashprog_seq
  import flashprog_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int LEN_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              ctlBit7,
  output logic              accReq,
  output logic              accWrite,
  output logic [1:0]        accRegSel,
  output logic [LEN_W-1:0]  accLen,
  output logic [ADDR_W-1:0] accWData,
  input  logic              accAck,
  input  logic              accErr,
  input  logic [9:0]        accRData,
  output logic [7:0]        rdByte,
  output logic              fail,
  output logic              done
);

  seqStrobe_t str;

  flashprog_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .op      (op),
    .accAck  (accAck),
    .accErr  (accErr),
    .busyBit (accRData[0]),
    .str     (str),
    .accReq  (accReq),
    .done    (done)
  );

  flashprog_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .op        (op),
    .addr      (addr),
    .wrData    (wrData),
    .ctlBit7   (ctlBit7),
    .accAck    (accAck),
    .accRData  (accRData),
    .accRegSel (accRegSel),
    .accWrite  (accWrite),
    .accLen    (accLen),
    .accWData  (accWData),
    .rdByte    (rdByte),
    .fail      (fail)
  );

endmodule

// File: tb/flashprog_seq_tb.sv
module flashprog_seq_tb_top;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = $clog2(ADDR_W + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        opIn = 2'd0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [7:0]        wrDataIn = '0;
  logic              b7In = 1'b0;
  logic              accReq, accWrite, done, fail;
  logic [1:0]        accRegSel;
  logic [LEN_W-1:0]  accLen;
  logic [ADDR_W-1:0] accWData;
  logic              accAck = 1'b0;
  logic              accErr = 1'b0;
  logic [9:0]        accRData = '0;
  logic [7:0]        rdByte;

  flashprog_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .op(opIn), .addr(addrIn),
    .wrData(wrDataIn), .ctlBit7(b7In), .accReq(accReq), .accWrite(accWrite),
    .accRegSel(accRegSel), .accLen(accLen), .accWData(accWData),
    .accAck(accAck), .accErr(accErr), .accRData(accRData),
    .rdByte(rdByte), .fail(fail), .done(done)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // expected access list
  int       expReg[32], expWr[32], expLen[32], expDat[32];
  int       expN = 0;
  int       seen = 0;
  int       gap = 0;
  int       errAt = -1;
  int       busyN = 0;
  bit       failBit = 0;
  bit       isRd = 0;
  bit [7:0] rdVal = 0;

  function automatic string tagFor(input int idx);
    if (idx <= 1) return "R3";
    if (idx == 2 || idx == 4) return "R4";
    if (idx == 3) return "R5";
    if (idx <= 5 + busyN) return "R6";
    return "R7";
  endfunction

  // access layer model
  always @(negedge clk) begin
    if (accAck) begin
      accAck   = 1'b0;
      accErr   = 1'b0;
      accRData = '0;
    end else if (accReq) begin
      if (gap > 0) gap--;
      else begin
        if (seen < expN)
          chk(accRegSel == expReg[seen] && accWrite == expWr[seen] &&
              accLen == expLen[seen] && accWData == expDat[seen], tagFor(seen),
              {accRegSel, 3'b0, accWrite, 3'b0, 3'b0, accLen, accWData},
              {expReg[seen][1:0], 3'b0, expWr[seen][0], 3'b0, 3'b0,
               expLen[seen][LEN_W-1:0], expDat[seen][ADDR_W-1:0]});
        else
          chk(1'b0, "R9 extra access", seen, expN);
        if (seen >= 5 && seen <= 5 + busyN)
          accRData = {9'h15A, (seen < 5 + busyN)};
        else if (seen == 6 + busyN)
          accRData = isRd ? {rdVal, failBit, 1'b0} : {8'hC3, failBit, 1'b0};
        else
          accRData = 10'h3FC;
        accErr = (seen == errAt);
        accAck = 1'b1;
        seen++;
        gap = seen % 2;
      end
    end
  end

  task automatic addExp(input int r, input int w, input int l, input int d, inout int n);
    expReg[n] = r; expWr[n] = w; expLen[n] = l; expDat[n] = d;
    n++;
  endtask

  task automatic runOp(input int op, input int a, input int d, input int b7,
                       input int bn, input int fb, input int rv, input int ea,
                       input bit midStart);
    int  n = 0;
    int  mode;
    bit  erred;
    int  expFail, expRb;
    bit  gotDone = 0;
    mode = (op == 0) ? 'h10 : (op == 1) ? 'h20 : 'h02;
    addExp(0, 1, 8, (op == 2) ? 'h80 : 'h81, n);
    addExp(1, 1, ADDR_W, a, n);
    addExp(2, 1, 8, mode | (b7 << 7), n);
    if (op == 0)      addExp(3, 1, 8, d, n);
    else if (op == 1) addExp(3, 1, 8, 'hA5, n);
    else              addExp(3, 0, 10, 0, n);
    addExp(2, 1, 8, b7 << 7, n);
    for (int p = 0; p <= bn; p++) addExp(3, 0, 1, 0, n);
    addExp(3, 0, (op == 2) ? 10 : 2, 0, n);
    erred   = (ea >= 0 && ea < n);
    expN    = erred ? ea + 1 : n;
    expFail = erred ? 1 : fb;
    expRb   = (erred || op != 2) ? 0 : rv;
    seen = 0; gap = 0; errAt = ea; busyN = bn; failBit = fb[0];
    isRd = (op == 2); rdVal = rv[7:0];
    @(negedge clk);
    opIn = op[1:0]; addrIn = a[ADDR_W-1:0]; wrDataIn = d[7:0]; b7In = b7[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (midStart && k == 3) begin
        start = 1'b1; opIn = 2'd2; addrIn = ~addrIn; b7In = ~b7In;
      end
      if (midStart && k == 4) start = 1'b0;
      if (done) begin gotDone = 1; break; end
    end
    start = 1'b0;
    chk(gotDone, "R10 done seen", gotDone, 1);
    chk(!accReq, "R10 no request with done", accReq, 0);
    chk(seen == expN, erred ? "R9 access count" : (midStart ? "R2 access count" : "R6 access count"), seen, expN);
    chk(fail == expFail[0], erred ? "R9 fail" : "R7 fail", fail, expFail);
    chk(rdByte == expRb[7:0], erred ? "R9 rdByte" : "R7 rdByte", rdByte, expRb);
    @(negedge clk);
    chk(!done, "R10 single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(fail == expFail[0] && rdByte == expRb[7:0], "R10 outputs held",
        {rdByte, fail}, {expRb[7:0], expFail[0]});
    chk(seen == expN && !accReq, "R9 idle after end", seen, expN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!accReq && !done && !fail && rdByte == 8'h00, "R1 reset state",
        {accReq, done, fail, rdByte}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!accReq && !done && !fail && rdByte == 8'h00, "R1 after release",
        {accReq, done, fail, rdByte}, 0);

    // R2: reserved code ignored
    expN = 0; seen = 0;
    opIn = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit anyAct = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (accReq || done) anyAct = 1;
      end
      chk(!anyAct && seen == 0, "R2 reserved op ignored", anyAct, 0);
    end

    // full sweep of operation, control bit, busy count and status fail bit
    for (int op = 0; op < 3; op++)
      for (int b7 = 0; b7 < 2; b7++)
        for (int bn = 0; bn < 4; bn++)
          for (int fb = 0; fb < 2; fb++) begin
            int idx = op * 16 + b7 * 8 + bn * 2 + fb;
            runOp(op, ('h1234 ^ (idx * 'h0913)) & 'hFFFF, (idx * 37 + 11) & 'hFF,
                  b7, bn, fb, (idx * 53 + 7) & 'hFF, -1, 1'b0);
          end

    // R9: error injected at every access position
    for (int op = 0; op < 3; op++)
      for (int ea = 0; ea < 8; ea++)
        runOp(op, 'hBEEF - ea, 'h5A + ea, ea % 2, 1, 0, 'h96, ea, 1'b0);

    // R2: start while busy ignored
    for (int op = 0; op < 2; op++)
      runOp(op, 'h0F0F, 'h3C, 0, 2, 0, 0, -1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule